// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single periodic timer channel for use inside an interrupt controller. Software programs a 32-bit base word whose top bit is an inhibit flag and whose lower 31 bits give the reload value. While the inhibit flag is clear, a 31-bit down-counter decrements once for each cycle in which the `tick` enable is high. When the counter runs out, it reloads from the base value, inverts a toggle flag and raises `irq_pulse` for exactly one clock cycle.

Counting is started and stopped only by changes to the inhibit flag. Clearing the flag (1 to 0) loads the counter from the written word and clears the toggle flag. Setting the flag (0 to 1) freezes the channel and zeroes the count, but the toggle flag keeps its value. A write that leaves the flag unchanged only updates the stored base word. The current count can be read through the same port, with the toggle flag in bit 31 and the remaining count in bits 30:0.

Top module: `tmr_channel`

## Requirements
- R1: After reset the base word reads 0x8000_0000 (inhibit set, reload 0), the count word reads 0x0000_0000, and `irq_pulse` is low.
- R2: Every write with `wr_sel`=0 stores `wr_data` as the base word. This holds even when bit 31 is unchanged. Such a write leaves the count word untouched, apart from any tick taken in the same cycle.
- R3: A base write that takes bit 31 from 1 to 0 sets the count word to {0, `wr_data`[30:0]} on the next clock edge.
- R4: A base write that takes bit 31 from 0 to 1 sets count bits 30:0 to zero and keeps bit 31 (the toggle). While inhibited, the count word does not change and `irq_pulse` stays low.
- R5: While not inhibited, a tick with a count above 1 lowers the count by exactly one. A cycle without a tick leaves the count unchanged.
- R6: While not inhibited, a tick with a count of 0 or 1 is an expiry. The count reloads from base bits 30:0, the toggle inverts, and `irq_pulse` is high in the following cycle.
- R7: With a reload value of 0, every tick is an expiry, so `irq_pulse` can be high on consecutive cycles.
- R8: `irq_pulse` is high only in the cycle after an expiry. A single expiry gives a pulse exactly one cycle wide.
- R9: Writes with `wr_sel`=1 are ignored. Neither the base word nor the count word changes.
- R10: A base write that changes bit 31 takes precedence over a tick in the same cycle. No decrement and no pulse come from that tick. An expiry in the same cycle as a base write that keeps bit 31 reloads from the base value held before that write.
- R11: `rd_data` is combinational. It returns the base word when `rd_sel`=0 and {toggle, count[30:0]} when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 base word, 1 count word (ignored) |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Count enable, one decrement per high cycle |
| rd_sel | input | 1 | Read target: 0 base word, 1 count word |
| rd_data | output | 32 | Read data |
| irq_pulse | output | 1 | One-cycle expiry pulse |

## Verification
A software write to the base word and a tick can reach the counter in the same clock cycle. The bench provokes this in three ways:
- an expiry tick together with a write that keeps the inhibit flag clear but changes the reload value;
- a stop write together with a tick;
- a start write together with a tick.

In each case the bench reads back the count word and samples `irq_pulse` in the following cycle. It judges whether the reload took the old base value and whether the flag change took precedence over the tick without a pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_DATA_W = 32;
    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_COUNT = 1'b1;
endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode (
    input  logic wr_en,
    input  logic wr_sel,
    input  logic wr_msb,
    input  logic inhibit_q,
    output logic base_we,
    output logic start,
    output logic stop
);
    always_comb begin
        base_we = wr_en && (wr_sel == tmr_pkg::SEL_BASE);
        // a start or stop happens only when a base write flips the inhibit flag
        start   = base_we && inhibit_q && !wr_msb;
        stop    = base_we && !inhibit_q && wr_msb;
    end
endmodule

// File: rtl/tmr_base_reg.sv
module tmr_base_reg #(
    parameter int unsigned DATA_W = tmr_pkg::TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] base_q
);
    localparam logic [DATA_W-1:0] BASE_RST = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] base_d;

    always_comb begin
        base_d = base_q;
        if (base_we) begin
            base_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
        end else begin
            base_q <= base_d;
        end
    end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int unsigned CNT_W = tmr_pkg::TMR_DATA_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tog_q,
    output logic             irq_q
);
    typedef struct packed {
        logic             tog;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start) begin
            st_d.cnt = load_val;
            st_d.tog = 1'b0;
        end else if (stop) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt = reload_val;
                st_d.tog = ~st_q.tog;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign tog_q = st_q.tog;
    assign irq_q = st_q.irq;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned DATA_W = tmr_pkg::TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse
);
    localparam int unsigned CNT_W = DATA_W - 1;

    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] count_word;
    logic [CNT_W-1:0]  cnt_q;
    logic              tog_q;
    logic              base_we, start, stop;

    tmr_wr_decode u_dec (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_msb    (wr_data[DATA_W-1]),
        .inhibit_q (base_q[DATA_W-1]),
        .base_we   (base_we),
        .start     (start),
        .stop      (stop)
    );

    tmr_base_reg #(.DATA_W(DATA_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_we (base_we),
        .wr_data (wr_data),
        .base_q  (base_q)
    );

    tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (!base_q[DATA_W-1]),
        .tick       (tick),
        .start      (start),
        .stop       (stop),
        .load_val   (wr_data[CNT_W-1:0]),
        .reload_val (base_q[CNT_W-1:0]),
        .cnt_q      (cnt_q),
        .tog_q      (tog_q),
        .irq_q      (irq_pulse)
    );

    assign count_word = {tog_q, cnt_q};
    assign rd_data    = (rd_sel == tmr_pkg::SEL_COUNT) ? count_word : base_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int unsigned DATA_W = tmr_pkg::TMR_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [DATA_W-1:0] base_q,
    input logic [DATA_W-1:0] count_q,
    input logic              irq
);
    localparam int unsigned CNT_W = DATA_W - 1;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && base_q[DATA_W-1] && !wr_data[DATA_W-1])
        |=> (count_q == {1'b0, $past(wr_data[CNT_W-1:0])}) && !irq); // R3

    AST_STOP_KEEPS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !base_q[DATA_W-1] && wr_data[DATA_W-1])
        |=> (count_q[CNT_W-1:0] == '0) && (count_q[DATA_W-1] == $past(count_q[DATA_W-1])) && !irq); // R4

    AST_INHIBIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q[DATA_W-1] && !(wr_en && !wr_sel && !wr_data[DATA_W-1]))
        |=> $stable(count_q) && !irq); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(count_q) && !irq); // R5

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !base_q[DATA_W-1] && tick && (count_q[CNT_W-1:0] > CNT_W'(1)))
        |=> (count_q[CNT_W-1:0] == $past(count_q[CNT_W-1:0]) - CNT_W'(1)) && !irq); // R5

    AST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !base_q[DATA_W-1] && tick && (count_q[CNT_W-1:0] <= CNT_W'(1)))
        |=> irq && (count_q[DATA_W-1] != $past(count_q[DATA_W-1]))
            && (count_q[CNT_W-1:0] == $past(base_q[CNT_W-1:0]))); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick) && !$past(base_q[DATA_W-1])); // R8

    AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !tick) |=> $stable(count_q) && $stable(base_q)); // R9
endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .tick    (tick),
    .base_q  (base_q),
    .count_q (count_word),
    .irq     (irq_pulse)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/100ps
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;

    tmr_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tick      (tick),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, return 0.5 ns after the capturing edge
    task automatic step(input logic we, input logic sel, input logic [31:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; tick = tk;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
    endtask

    task automatic chk_cnt(input string req, input logic [31:0] exp);
        rd_sel = 1'b1; #0.2;
        chk(req, rd_data, exp);
    endtask

    task automatic chk_base(input string req, input logic [31:0] exp);
        rd_sel = 1'b0; #0.2;
        chk(req, rd_data, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, {31'b0, irq_pulse}, {31'b0, exp});
    endtask

    task automatic t_reset;
        chk_base("R1 base after reset", 32'h8000_0000);
        chk_cnt("R1 count after reset", 32'h0000_0000);
        chk_irq("R1 irq after reset", 1'b0);
    endtask

    task automatic t_start_and_count;
        step(1, 0, 32'h0000_0005, 0);
        chk_cnt("R3 start loads count", 32'h0000_0005);
        chk_base("R11 base readback", 32'h0000_0005);
        for (int i = 4; i >= 1; i--) begin
            step(0, 0, 0, 1);
            chk_cnt("R5 decrement", 32'(i));
            chk_irq("R8 no irq while counting", 1'b0);
        end
        step(0, 0, 0, 0);
        chk_cnt("R5 no tick holds", 32'h0000_0001);
        step(0, 0, 0, 1);
        chk_cnt("R6 expiry reload toggles", 32'h8000_0005);
        chk_irq("R6 irq on expiry", 1'b1);
        step(0, 0, 0, 0);
        chk_irq("R8 pulse one cycle", 1'b0);
    endtask

    task automatic t_rewrite_running;
        step(1, 0, 32'h0000_0003, 0);
        chk_base("R2 base stored without flag change", 32'h0000_0003);
        chk_cnt("R2 count untouched", 32'h8000_0005);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        chk_cnt("R5 counted down to 1", 32'h8000_0001);
        step(0, 0, 0, 1);
        chk_cnt("R6 reload from new base", 32'h0000_0003);
        chk_irq("R6 irq second expiry", 1'b1);
    endtask

    task automatic t_count_write_ignored;
        step(1, 1, 32'h1234_5678, 0);
        chk_cnt("R9 count write ignored", 32'h0000_0003);
        chk_base("R9 base unaffected", 32'h0000_0003);
    endtask

    task automatic t_stop;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        chk_cnt("R6 third expiry", 32'h8000_0003);
        step(1, 0, 32'h8000_0007, 0);
        chk_cnt("R4 stop keeps toggle", 32'h8000_0000);
        chk_base("R2 base stored on stop", 32'h8000_0007);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 1);
            chk_irq("R4 no irq while inhibited", 1'b0);
        end
        chk_cnt("R4 frozen while inhibited", 32'h8000_0000);
        step(1, 0, 32'h8000_0009, 0);
        chk_base("R2 base stored while inhibited", 32'h8000_0009);
        chk_cnt("R2 count untouched while inhibited", 32'h8000_0000);
    endtask

    task automatic t_zero_reload;
        step(1, 0, 32'h0000_0000, 0);
        chk_cnt("R3 start clears toggle", 32'h0000_0000);
        step(0, 0, 0, 1);
        chk_cnt("R7 zero reload expiry", 32'h8000_0000);
        chk_irq("R7 irq first tick", 1'b1);
        step(0, 0, 0, 1);
        chk_cnt("R7 zero reload expiry again", 32'h0000_0000);
        chk_irq("R7 irq consecutive", 1'b1);
        step(0, 0, 0, 0);
        chk_irq("R8 irq drops", 1'b0);
    endtask

    task automatic t_collision;
        step(1, 0, 32'h8000_0000, 0);
        step(1, 0, 32'h0000_0002, 0);
        step(0, 0, 0, 1);
        chk_cnt("R5 at 1 before collision", 32'h0000_0001);
        step(1, 0, 32'h0000_0006, 1);
        chk_cnt("R10 expiry uses old base", 32'h8000_0002);
        chk_irq("R10 irq with base write", 1'b1);
        chk_base("R10 new base stored", 32'h0000_0006);
        step(0, 0, 0, 1);
        step(1, 0, 32'h8000_0006, 1);
        chk_cnt("R10 stop beats tick", 32'h8000_0000);
        chk_irq("R10 no irq on stop", 1'b0);
        step(1, 0, 32'h0000_0004, 1);
        chk_cnt("R10 start beats tick", 32'h0000_0004);
        chk_irq("R10 no irq on start", 1'b0);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(posedge clk); #0.5;
        t_reset();
        t_start_and_count();
        t_rewrite_running();
        t_count_write_ignored();
        t_stop();
        t_zero_reload();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule